// File: doc/BRIEF.md
# Thermal Throttle Clock Modulator

This block cuts the heat output of a processor core by gating its clock enable on and off in a repeating pattern. A free-running modulation period of `PERIOD` core clock cycles is split into an off phase followed by an on phase. Two sources can start throttling. The automatic source follows an 8-bit die temperature code against a build-time trip point, with hysteresis. The on-demand source is a software request with a 3-bit duty setting. When both sources ask for throttling, the automatic source decides the pattern.

The chosen pattern is captured only at a period boundary, so the output never carries a shortened off or on phase. Interrupt request lines pass through while the clock is enabled. A request that arrives while the clock is gated off is held back. It is delivered as one pulse in the first cycle of the next on phase.

Top module: `thermal_throttle_mod`

## Requirements
- R1: While `rst_n` is low (synchronous, active low) and for the first period after release, `core_clk_en` is 1, `throttling` is 0, and `irq_out` is 0 when `irq_in` is 0.
- R2: Automatic throttling uses a fixed 50% pattern. In each period of `PERIOD` cycles (default 16), phase positions 0 to PERIOD/2-1 are off and the rest are on, whatever `dmd_duty` holds.
- R3: The trip point `TRIP` (default 100) is a parameter only. Automatic throttling starts when `auto_en` is 1 and `temp_code` >= `TRIP`, and takes effect from the next period boundary.
- R4: With `auto_en` at 0, `temp_code` has no effect. A code of 255 gives no throttling.
- R5: Automatic throttling that has started stays on while `temp_code` >= `TRIP - HYST` (default 96). It ends only once `temp_code` < `TRIP - HYST`.
- R6: When no source requests throttling, `core_clk_en` stays 1 for the whole period and `throttling` reads 0.
- R7: On-demand throttling (`dmd_en` = 1) with duty code k from 1 to 7 gives k*PERIOD/8 on cycles, placed at the end of the period after PERIOD - k*PERIOD/8 off cycles. Code 0 gives no throttling.
- R8: When automatic throttling is active and an on-demand request is also present, the 50% automatic pattern is used.
- R9: A change to `auto_en`, `dmd_en`, `dmd_duty` or the temperature state takes effect only at the next period boundary. The period under way finishes with its old pattern.
- R10: For each line, an `irq_in` request raised while `core_clk_en` is 0 is held. It appears on `irq_out` for exactly one cycle at the first on cycle. Several assertions during one off phase merge into one pulse. `irq_out` is 0 whenever `core_clk_en` is 0.
- R11: While `core_clk_en` is 1, `irq_out` follows `irq_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_code | input | TEMP_W (8) | Unsigned die temperature code |
| auto_en | input | 1 | Enables temperature-driven throttling |
| dmd_en | input | 1 | On-demand throttle request |
| dmd_duty | input | 3 | On-demand on-time in eighths of a period |
| irq_in | input | IRQ_N (4) | Incoming interrupt requests |
| core_clk_en | output | 1 | Gated clock enable for the core |
| throttling | output | 1 | Throttling pattern active in this period |
| irq_out | output | IRQ_N (4) | Interrupt requests presented to the core |

## Verification
The pattern generator is exercised with the automatic source, with on-demand duties 1, 4 and 7, and with both sources at once. These runs separate the fixed 50% split from the programmable one and show which source wins. Temperature is walked through 99, 100, 97 and 95 to tell the trip edge apart from the release edge of the hysteresis band. A code of 255 with the mode disabled shows the input is ignored. A duty change in the middle of a period checks that patterns switch only at a boundary. Interrupt pulses in the off phase, some repeated and some not, together with a request during the on phase, separate latched delivery and merging from pass-through.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_DEMAND = 2'd1,
    SRC_AUTO   = 2'd2
  } thr_src_e;

  // Number of on cycles in one period for a given source and duty.
  function automatic int unsigned on_len(thr_src_e src, logic [2:0] duty,
                                         int unsigned period);
    int unsigned r;
    case (src)
      SRC_AUTO:   r = period / 2;
      SRC_DEMAND: r = int'(duty) * (period / 8);
      default:    r = period;
    endcase
    return r;
  endfunction

  // Source arbitration: automatic throttling wins over the software request.
  function automatic thr_src_e pick_src(logic hot, logic dmd_en, logic [2:0] duty);
    thr_src_e s;
    if (hot)                         s = SRC_AUTO;
    else if (dmd_en && duty != 3'd0) s = SRC_DEMAND;
    else                             s = SRC_NONE;
    return s;
  endfunction

endpackage

// File: rtl/thr_hyst_trip.sv
module thr_hyst_trip #(
  parameter int TEMP_W = 8,
  parameter int TRIP   = 100,
  parameter int HYST   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hot
);
  localparam logic [TEMP_W-1:0] TRIP_C = TEMP_W'(TRIP);
  localparam logic [TEMP_W-1:0] REL_C  = TEMP_W'(TRIP - HYST);

  logic reach_trip;
  logic below_rel;

  assign reach_trip = (temp_code >= TRIP_C);
  assign below_rel  = (temp_code <  REL_C);

  always_ff @(posedge clk) begin
    if (!rst_n)          hot <= 1'b0;
    else if (!auto_en)   hot <= 1'b0;
    else if (!hot)       hot <= reach_trip;
    else if (below_rel)  hot <= 1'b0;
  end
endmodule

// File: rtl/thr_phase_ctr.sv
module thr_phase_ctr #(
  parameter int PERIOD = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [$clog2(PERIOD)-1:0] phase,
  output logic                      wrap
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  assign wrap = (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    phase <= '0;
    else if (wrap) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/thr_duty_sel.sv
module thr_duty_sel
  import thr_pkg::*;
#(
  parameter int PERIOD = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hot,
  input  logic                        dmd_en,
  input  logic [2:0]                  dmd_duty,
  input  logic                        wrap,
  input  logic [$clog2(PERIOD)-1:0]   phase,
  output logic [$clog2(PERIOD+1)-1:0] act_on,
  output thr_src_e                    act_src,
  output logic                        clk_en
);
  localparam int CW = $clog2(PERIOD);
  localparam int OW = $clog2(PERIOD + 1);
  localparam logic [OW-1:0] FULL = OW'(PERIOD);

  thr_src_e      req_src;
  logic [OW-1:0] req_on;
  logic [OW-1:0] off_len;

  assign req_src = pick_src(hot, dmd_en, dmd_duty);
  assign req_on  = OW'(on_len(req_src, dmd_duty, PERIOD));

  // Settings are captured only when the phase counter wraps.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_on  <= FULL;
      act_src <= SRC_NONE;
    end else if (wrap) begin
      act_on  <= req_on;
      act_src <= req_src;
    end
  end

  assign off_len = FULL - act_on;
  assign clk_en  = ({1'b0, phase} >= (OW + 1)'(off_len));

  logic unused_cw;
  assign unused_cw = (CW == 0);
endmodule

// File: rtl/thr_irq_hold.sv
module thr_irq_hold #(
  parameter int IRQ_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [IRQ_N-1:0] irq_in,
  output logic [IRQ_N-1:0] irq_out,
  output logic [IRQ_N-1:0] pending
);
  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)      pending[i] <= 1'b0;
      else if (clk_en) pending[i] <= 1'b0;
      else             pending[i] <= pending[i] | irq_in[i];
    end
    assign irq_out[i] = clk_en & (pending[i] | irq_in[i]);
  end
endmodule

// File: rtl/thermal_throttle_mod.sv
module thermal_throttle_mod
  import thr_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int TRIP   = 100,
  parameter int HYST   = 4,
  parameter int PERIOD = 16,
  parameter int IRQ_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              auto_en,
  input  logic              dmd_en,
  input  logic [2:0]        dmd_duty,
  input  logic [IRQ_N-1:0]  irq_in,
  output logic              core_clk_en,
  output logic              throttling,
  output logic [IRQ_N-1:0]  irq_out
);
  localparam int CW = $clog2(PERIOD);
  localparam int OW = $clog2(PERIOD + 1);

  initial begin
    if (PERIOD % 8 != 0 || PERIOD < 8) $error("PERIOD must be a multiple of 8");
    if (TRIP < HYST) $error("HYST exceeds TRIP");
  end

  // Named internal events, visible to the bound checker.
  logic          auto_hot;
  logic          period_wrap;
  logic [CW-1:0] phase;
  logic [OW-1:0] act_on;
  thr_src_e      act_src;
  logic [IRQ_N-1:0] irq_pending;

  thr_hyst_trip #(.TEMP_W(TEMP_W), .TRIP(TRIP), .HYST(HYST)) trip_i (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .temp_code(temp_code),
    .hot(auto_hot)
  );

  thr_phase_ctr #(.PERIOD(PERIOD)) ctr_i (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wrap(period_wrap)
  );

  thr_duty_sel #(.PERIOD(PERIOD)) duty_i (
    .clk(clk), .rst_n(rst_n), .hot(auto_hot), .dmd_en(dmd_en),
    .dmd_duty(dmd_duty), .wrap(period_wrap), .phase(phase),
    .act_on(act_on), .act_src(act_src), .clk_en(core_clk_en)
  );

  thr_irq_hold #(.IRQ_N(IRQ_N)) irq_i (
    .clk(clk), .rst_n(rst_n), .clk_en(core_clk_en), .irq_in(irq_in),
    .irq_out(irq_out), .pending(irq_pending)
  );

  assign throttling = (act_src != SRC_NONE);
endmodule

// File: rtl/thermal_throttle_chk.sv
module thermal_throttle_chk #(
  parameter int TEMP_W = 8,
  parameter int TRIP   = 100,
  parameter int HYST   = 4,
  parameter int PERIOD = 16,
  parameter int IRQ_N  = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [TEMP_W-1:0]           temp_code,
  input logic                        auto_en,
  input logic                        auto_hot,
  input logic                        period_wrap,
  input logic [$clog2(PERIOD+1)-1:0] act_on,
  input logic                        core_clk_en,
  input logic                        throttling,
  input logic [IRQ_N-1:0]            irq_in,
  input logic [IRQ_N-1:0]            irq_out
);
  localparam int OW = $clog2(PERIOD + 1);

  p_trip_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && temp_code >= TEMP_W'(TRIP)) |=> auto_hot);

  p_mode_off_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !auto_hot);

  p_hyst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_hot && auto_en && temp_code >= TEMP_W'(TRIP - HYST)) |=> auto_hot);

  p_idle_full_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !throttling |-> core_clk_en);

  p_auto_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_hot && period_wrap) |=> (act_on == OW'(PERIOD / 2)));

  p_boundary_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !period_wrap |=> $stable(act_on));

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> (irq_out == '0));

  p_irq_delivered_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && irq_in != '0) |=>
      (!core_clk_en || ((irq_out & $past(irq_in)) == $past(irq_in))));

  p_irq_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> ((irq_out & irq_in) == irq_in));
endmodule

bind thermal_throttle_mod thermal_throttle_chk #(
  .TEMP_W(TEMP_W), .TRIP(TRIP), .HYST(HYST), .PERIOD(PERIOD), .IRQ_N(IRQ_N)
) chk_i (
  .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .auto_en(auto_en),
  .auto_hot(auto_hot), .period_wrap(period_wrap), .act_on(act_on),
  .core_clk_en(core_clk_en), .throttling(throttling),
  .irq_in(irq_in), .irq_out(irq_out)
);

// File: tb/thermal_throttle_mod_tb_top.sv
module thermal_throttle_mod_tb_top;
  localparam int PER = 16;
  localparam int NI  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    temp_code = 8'd25;
  logic          auto_en = 1'b0;
  logic          dmd_en = 1'b0;
  logic [2:0]    dmd_duty = 3'd0;
  logic [NI-1:0] irq_in = '0;
  logic          core_clk_en;
  logic          throttling;
  logic [NI-1:0] irq_out;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;   // posedges since reset release; phase = cyc % PER
  bit done   = 0;

  always #10 clk = ~clk;

  thermal_throttle_mod dut_i (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .auto_en(auto_en),
    .dmd_en(dmd_en), .dmd_duty(dmd_duty), .irq_in(irq_in),
    .core_clk_en(core_clk_en), .throttling(throttling), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at phase %0d: actual %0d expected %0d", req, cyc % PER, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  // Advance to the start of a period; two boundaries make new inputs certain to load.
  task automatic to_start();
    for (int b = 0; b < 2; b++) begin
      tick();
      while (cyc % PER != 0) tick();
    end
  endtask

  // Check one full period against an expected on-count (off phase first).
  task automatic chk_period(input int on_cnt, input string req);
    for (int c = 0; c < PER; c++) begin
      chk(core_clk_en == (c >= PER - on_cnt), req, core_clk_en, c >= PER - on_cnt);
      chk(throttling == (on_cnt < PER), req, throttling, on_cnt < PER);
      tick();
    end
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk);
      chk(core_clk_en == 1'b1, "R1", core_clk_en, 1);
      chk(throttling == 1'b0, "R1", throttling, 0);
      chk(irq_out == '0, "R1", irq_out, 0);
    end
    rst_n = 1'b1;
    cyc = 0;
    chk_period(PER, "R1");
  endtask

  task automatic t_disabled_ignored();
    auto_en = 1'b0; temp_code = 8'd255;
    to_start();
    chk_period(PER, "R4");
  endtask

  task automatic t_trip_and_hyst();
    auto_en = 1'b1; temp_code = 8'd99;
    to_start();
    chk_period(PER, "R3 below trip");
    temp_code = 8'd100;
    to_start();
    chk_period(PER / 2, "R3 R2 at trip");
    temp_code = 8'd97;
    to_start();
    chk_period(PER / 2, "R5 in band");
    temp_code = 8'd95;
    to_start();
    chk_period(PER, "R5 R6 released");
  endtask

  task automatic t_demand();
    auto_en = 1'b0; temp_code = 8'd30; dmd_en = 1'b1;
    dmd_duty = 3'd1; to_start(); chk_period(2, "R7 duty1");
    dmd_duty = 3'd7; to_start(); chk_period(14, "R7 duty7");
    dmd_duty = 3'd0; to_start(); chk_period(PER, "R7 duty0");
    dmd_en = 1'b0;
  endtask

  task automatic t_priority();
    dmd_en = 1'b1; dmd_duty = 3'd1; auto_en = 1'b1; temp_code = 8'd120;
    to_start();
    chk_period(PER / 2, "R8");
    auto_en = 1'b0; dmd_en = 1'b0; temp_code = 8'd30;
    to_start();
    chk_period(PER, "R6");
  endtask

  task automatic t_boundary();
    dmd_en = 1'b1; dmd_duty = 3'd4;
    to_start();
    for (int c = 0; c < PER; c++) begin
      if (c == 4) dmd_duty = 3'd7;
      chk(core_clk_en == (c >= 8), "R9 old pattern kept", core_clk_en, c >= 8);
      tick();
    end
    chk_period(14, "R9 new pattern");
    dmd_en = 1'b0; dmd_duty = 3'd0;
  endtask

  task automatic t_irq();
    auto_en = 1'b1; temp_code = 8'd110;
    to_start();
    for (int c = 0; c < PER; c++) begin
      irq_in = '0;
      if (c == 2 || c == 5) irq_in = 4'b0010;
      if (c == 6)           irq_in = 4'b0100;
      if (c == 11)          irq_in = 4'b1000;
      #1;
      if (c < 8)       chk(irq_out == '0, "R10 gated", irq_out, 0);
      else if (c == 8) chk(irq_out == 4'b0110, "R10 delivered", irq_out, 6);
      else if (c == 11) chk(irq_out == 4'b1000, "R11 pass", irq_out, 8);
      else             chk(irq_out == '0, "R10 single pulse", irq_out, 0);
      tick();
    end
    irq_in = '0; auto_en = 1'b0;
    to_start();
  endtask

  initial begin
    t_reset();
    t_disabled_ignored();
    t_trip_and_hyst();
    t_demand();
    t_priority();
    t_boundary();
    t_irq();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule